// File: doc/BRIEF.md
# Command-Driven Serial Register Port

This block is the device-side front end of a three-wire serial link (clock, data in, data out) into a converter-style chip. Chip select is treated as always active. Every exchange opens with an eight-bit command byte. The byte names one of eight internal registers and says whether a write or a read follows. The block then moves that register's bits in or out at the register's own width, and afterwards waits for the next command. The registers themselves live outside the block, behind one combinational read port and one write-strobe port.

Two recovery paths sit alongside the normal exchange. A sticky streaming mode shifts the conversion-result register out on every burst of clocks without a fresh command. That mode is left only by a specific exit byte, and only while the data-ready input is low. A long unbroken run of ones on the data input returns the whole interface to its idle state from any state and raises a one-cycle reset request for the rest of the chip.

The serial clock is oversampled in the system clock domain and must be synchronous to it. Each serial clock phase must last at least two system clocks. The serial clock idles high.

Top module: `serial_reg_port`

## Requirements
- R1: After `rst_n` is released the port waits for a command with `dout`=0, `rf_we`=0 and `reset_req`=0.
- R2: While waiting for a command, a 1 sampled as the first command bit is discarded and the bit position does not advance. The command starts with the first 0.
- R3: `din` is sampled on rising `sclk` edges, MSB first. Command bit 7 is the enable (must be 0). Bit 6 is 1 for read and 0 for write. Bits 5:3 hold the register address. Bit 2 is the streaming flag. Bits 1:0 are ignored, whatever their value.
- R4: The transfer width is 8 bits for addresses 0, 4 and 5, 16 bits for addresses 1 and 2, and 24 bits for addresses 3, 6 and 7. Register data is right-aligned on `rf_rdata` and `rf_wdata`.
- R5: On a read, the register value is captured at the first falling `sclk` edge. `dout` changes only after falling edges and presents that value MSB first. After the rising edge of the last bit the port waits for a command again.
- R6: On a write, `rf_we` pulses for exactly one cycle with `rf_waddr` and the assembled value, and only after the last data bit. A transfer cut short by `rst_n` writes nothing.
- R7: A write command to address 0 transfers no data and writes nothing. The next byte is taken as a new command.
- R8: A read of address 3 with the streaming flag set (0x5C) enters streaming mode. Every later burst shifts out address 3, captured afresh at that burst's first falling edge.
- R9: In streaming mode the last eight `din` bits forming 0x58 exit to command wait, but only if `drdy_n` is low at that last bit. With `drdy_n` high the mode continues.
- R10: The 32nd consecutive 1 on `din`, in any state, returns the port to command wait, clears streaming mode and pulses `reset_req` for one cycle.
- R11: Any 0 on `din` clears the run of ones. 31 ones do not trigger R10, and a run longer than 32 triggers it only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| drdy_n | input | 1 | Data-ready, low when a new result is available |
| dout | output | 1 | Serial data to the host |
| rf_raddr | output | 3 | Register file read address |
| rf_rdata | input | 24 | Register file read data, right-aligned |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 3 | Register file write address |
| rf_wdata | output | 24 | Register file write data, right-aligned |
| reset_req | output | 1 | One-cycle pulse after a run of 32 ones |

## Verification
The bench sends leading ones ahead of a command; a port that advanced on them would misread the address and return the wrong register. It stops a write with `rst_n` partway through and reads the target back; early committing would show as an unexpected strobe. It tries the exit byte once with data-ready high and once with it low. A port that ignored data-ready, or failed to exit, would return the wrong bits on the following read. It also sends runs of exactly 31 and of 40 ones from streaming mode, which expose an off-by-one in the ones counter, a counter that wraps, or a reset that leaves streaming mode on.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int DW       = 24,
  parameter int ONES_RST = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          din,
  input  logic          drdy_n,
  output logic          dout,
  output logic [2:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [2:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          reset_req
);
  localparam int CW = $clog2(DW + 1);
  localparam int OW = $clog2(ONES_RST + 1);
  localparam int W_BYTE = 8;
  localparam int W_WORD = 16;
  localparam logic [7:0] EXIT_CMD = 8'h58;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_ARM, ST_RD} st_t;

  st_t            st;
  logic           sclk_q;
  logic [CW-1:0]  cnt;
  logic [5:0]     cmd_sh;
  logic [2:0]     addr;
  logic           cont;
  logic [DW-1:0]  sh;
  logic [OW-1:0]  ones;
  logic [7:0]     mon;

  function automatic logic [CW-1:0] width_of(input logic [2:0] a);
    case (a)
      3'd1, 3'd2:       width_of = CW'(W_WORD);
      3'd3, 3'd6, 3'd7: width_of = CW'(DW);
      default:          width_of = CW'(W_BYTE);
    endcase
  endfunction

  wire rise = sclk & ~sclk_q;
  wire fall = ~sclk & sclk_q;
  wire [CW-1:0] cur_w = width_of(addr);
  wire [CW-1:0] cmd_w = width_of(cmd_sh[4:2]);
  wire [DW-1:0] aligned = rf_rdata << (DW - int'(cur_w));
  wire [DW-1:0] wmask = ~({DW{1'b1}} << cur_w);
  wire ones_hit = rise && din && (ones == OW'(ONES_RST - 1));
  wire exit_hit = rise && cont && !drdy_n && ({mon[6:0], din} == EXIT_CMD);

  assign rf_raddr = addr;
  assign rf_waddr = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_CMD;
      sclk_q <= 1'b1;
      cnt <= '0;
      cmd_sh <= '0;
      addr <= '0;
      cont <= 1'b0;
      sh <= '0;
      ones <= '0;
      mon <= '0;
      dout <= 1'b0;
      rf_we <= 1'b0;
      rf_wdata <= '0;
      reset_req <= 1'b0;
    end else begin
      sclk_q <= sclk;
      rf_we <= 1'b0;
      reset_req <= 1'b0;
      if (rise) begin
        mon <= {mon[6:0], din};
        if (!din) ones <= '0;
        else if (ones != OW'(ONES_RST)) ones <= ones + 1'b1;
      end
      if (ones_hit) begin
        st <= ST_CMD;
        cnt <= '0;
        cont <= 1'b0;
        reset_req <= 1'b1;
      end else if (exit_hit) begin
        st <= ST_CMD;
        cnt <= '0;
        cont <= 1'b0;
      end else begin
        case (st)
          ST_CMD: if (rise && !(cnt == '0 && din)) begin
            cmd_sh <= {cmd_sh[4:0], din};
            if (cnt == CW'(7)) begin
              cnt <= '0;
              addr <= cmd_sh[4:2];
              if (cmd_sh[5]) begin
                st <= ST_ARM;
                cont <= (cmd_sh[4:2] == 3'd3) && cmd_sh[1];
                mon <= '0;
              end else if (cmd_sh[4:2] != 3'd0 && cmd_w != '0) begin
                st <= ST_WR;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WR: if (rise) begin
            sh <= {sh[DW-2:0], din};
            if (cnt == cur_w - 1'b1) begin
              rf_we <= 1'b1;
              rf_wdata <= {sh[DW-2:0], din} & wmask;
              st <= ST_CMD;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ARM: if (fall) begin
            dout <= aligned[DW-1];
            sh <= aligned << 1;
            cnt <= CW'(1);
            st <= ST_RD;
          end
          ST_RD: if (fall && cnt != cur_w) begin
            dout <= sh[DW-1];
            sh <= sh << 1;
            cnt <= cnt + 1'b1;
          end else if (rise && cnt == cur_w) begin
            st <= cont ? ST_ARM : ST_CMD;
            cnt <= '0;
          end
          default: st <= ST_CMD;
        endcase
      end
    end
  end

  // R5
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dout));

  // R6
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R6
  we_from_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(st == ST_WR));

  // R9
  cont_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cont) && !reset_req) |-> $past(!drdy_n));

  // R10
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R10
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (st == ST_CMD && !cont && cnt == '0));

  // R11
  rst_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(din));
endmodule

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic drdy_n = 1'b1;
  logic dout, rf_we, reset_req;
  logic [2:0] rf_raddr, rf_waddr;
  logic [23:0] rf_rdata, rf_wdata;

  logic [23:0] regs [8];
  logic [23:0] data_val = 24'hA5C3E1;
  logic [26:0] exp_wr[$];
  logic [23:0] exp_rd[$];
  int total = 0, fails = 0, rst_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .drdy_n(drdy_n),
    .dout(dout), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .reset_req(reset_req));

  assign rf_rdata = (rf_raddr == 3'd3) ? data_val : regs[rf_raddr];

  initial begin
    regs[0] = 24'h8A;   regs[1] = 24'h000A; regs[2] = 24'h0710; regs[3] = 24'h0;
    regs[4] = 24'h49;   regs[5] = 24'h00;   regs[6] = 24'h800000; regs[7] = 24'h5A5A5A;
  end

  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (reset_req) rst_cnt++;
    if (rf_we) begin
      if (exp_wr.size() == 0) chk(0, "R6 unexpected write strobe", {rf_waddr, rf_wdata[20:0]}, 24'h0);
      else begin
        logic [26:0] e;
        e = exp_wr.pop_front();
        chk({rf_waddr, rf_wdata} == e, "R6 write address/data", rf_wdata, e[23:0]);
      end
    end
  end

  function automatic int wbits(input logic [2:0] a);
    case (a)
      3'd1, 3'd2: return 16;
      3'd3, 3'd6, 3'd7: return 24;
      default: return 8;
    endcase
  endfunction

  task automatic xfer(input int n, input logic [23:0] w, output logic [23:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 1'b0; din = w[i];
      repeat (4) @(negedge clk);
      got[i] = dout;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [23:0] junk;
    xfer(8, {16'h0, b}, junk);
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [23:0] exp, input string tag);
    logic [23:0] got, e;
    exp_rd.push_back(exp);
    send_byte(cmd);
    xfer(wbits(cmd[5:3]), 24'h0, got);
    e = exp_rd.pop_front();
    chk(got == e, tag, got, e);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [23:0] v);
    int n;
    n = wbits(a);
    exp_wr.push_back({a, v & ((24'h1 << n) - 24'h1) | (n == 24 ? v : 24'h0)});
    send_byte({2'b00, a, 3'b000});
    xfer(n, v, v);
    repeat (2) @(negedge clk);
    chk(exp_wr.size() == 0, "R6 write committed after last bit", 24'(exp_wr.size()), 24'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [23:0] got;
    int r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk(dout == 1'b0 && rf_we == 1'b0 && reset_req == 1'b0, "R1 reset state",
        {21'h0, dout, rf_we, reset_req}, 24'h0);

    // R4 R5: 8-bit read of address 4
    do_read(8'h60, 24'h49, "R5 read ID byte");
    // R4 R6: 16-bit write and readback
    do_write(3'd1, 24'h1234);
    do_read(8'h48, 24'h1234, "R4 16-bit readback");
    // R4: 24-bit write and readback
    do_write(3'd6, 24'hFEDCBA);
    do_read(8'h70, 24'hFEDCBA, "R4 24-bit readback");

    // R2: leading ones before the enable bit
    for (int i = 0; i < 7; i++) xfer(1, 24'h1, got);
    do_read(8'h60, 24'h49, "R2 leading ones skipped");

    // R11: 31 ones do not reset
    do_write(3'd5, 24'h3C);
    r0 = rst_cnt;
    for (int i = 0; i < 31; i++) xfer(1, 24'h1, got);
    do_read(8'h68, 24'h3C, "R11 read after 31 ones");
    chk(rst_cnt == r0, "R11 no reset after 31 ones", 24'(rst_cnt - r0), 24'h0);

    // R3: reserved bits ignored
    do_read(8'h63, 24'h49, "R3 reserved bits ignored");

    // R7: write to address 0 is a no-op
    send_byte(8'h00);
    send_byte(8'h07);
    do_read(8'h40, 24'h8A, "R7 status after address-0 writes");

    // R6: partial write cut by rst_n
    send_byte(8'h10);
    xfer(7, 24'h7F, got);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(8'h50, 24'h0710, "R6 partial write leaves register");

    // R8: streaming mode
    send_byte(8'h5C);
    xfer(24, 24'h0, got);
    chk(got == 24'hA5C3E1, "R8 first stream burst", got, 24'hA5C3E1);
    data_val = 24'h123456;
    xfer(24, 24'h0, got);
    chk(got == 24'h123456, "R8 stream burst fresh snapshot", got, 24'h123456);

    // R9: exit byte ignored with drdy_n high
    xfer(24, {8'h58, 16'h0}, got);
    chk(got == 24'h123456, "R9 burst carrying exit byte, ready high", got, 24'h123456);
    xfer(24, 24'h0, got);
    chk(got == 24'h123456, "R9 still streaming with ready high", got, 24'h123456);

    // R9: exit byte honoured with drdy_n low
    drdy_n = 1'b0;
    xfer(24, {8'h58, 16'h0}, got);
    chk(got[23:16] == 8'h12, "R9 bits before exit", {16'h0, got[23:16]}, 24'h12);
    drdy_n = 1'b1;
    do_read(8'h60, 24'h49, "R9 command wait after exit");

    // R10 R11: 40 ones from streaming mode
    send_byte(8'h5C);
    r0 = rst_cnt;
    for (int i = 0; i < 40; i++) xfer(1, 24'h1, got);
    chk(rst_cnt == r0 + 1, "R11 single reset pulse for 40 ones", 24'(rst_cnt - r0), 24'h1);
    do_read(8'h60, 24'h49, "R10 streaming cleared by ones reset");

    // R10: ones reset from command wait
    r0 = rst_cnt;
    for (int i = 0; i < 32; i++) xfer(1, 24'h1, got);
    chk(rst_cnt == r0 + 1, "R10 reset pulse from idle", 24'(rst_cnt - r0), 24'h1);
    do_read(8'h58, 24'h123456, "R10 command accepted after reset");

    repeat (10) @(negedge clk);
    chk(exp_wr.size() == 0, "R6 no pending writes", 24'(exp_wr.size()), 24'h0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule